// File: doc/BRIEF.md
# Dual-Channel ADC Capture Sequencer

This block sits on the host side of a two-channel converter that shares one pipelined A/D core between two sample-and-hold stages. It drives the converter's active-low power-down line, its sampling-mode line and its channel-select line. It also receives the 14-bit parallel words that the converter returns. One system clock cycle equals one conversion clock. The select line is registered, so it settles well inside the cycle before the edge at which the converter samples it.

After power-down is released, the block counts a programmable number of start-up cycles. When the count ends, it begins alternating the select line between channel 1 and channel 2 on every cycle. At each sampling edge it issues a tag holding a valid bit, the channel and a sample index. The tag travels through a nine-stage delay line, so that it meets the converter's word as that word is registered. The converter has eight cycles of latency, and the input register adds one more.

The block supports two sampling modes:
- In separate-sampling mode, every word has its own index.
- In simultaneous mode, both channels are acquired on the select-low edge. The channel-2 word of the pair comes out one cycle after the channel-1 word and carries the same index.

Output words can be passed on as straight binary or converted to two's complement.

Top module: `adc_capture_seq`

## Requirements
- R1: When `enable` is sampled low at a clock edge, `adc_pdn_n` and `out_valid` are both low after that edge. After reset both are low and `adc_sel` is 0.
- R2: During the start-up wait, `adc_sel` stays 0. Once the wait is over, `adc_sel` toggles on every cycle, starting with a cycle at 0 (channel 1); 1 selects channel 2.
- R3: Once `enable` is seen high, the first valid output word appears after exactly STARTUP_CYC+11 rising edges, counting the edge that samples `enable` high. The start-up counter completes exactly STARTUP_CYC cycles after power-down is released.
- R4: Valid output words come out on consecutive cycles. `out_chan` alternates 0,1,0,1 starting at 0 (0 = channel 1, 1 = channel 2).
- R5: In separate mode (`mode_req`=0), `out_index` starts at 0 after each start-up and goes up by one on every word.
- R6: In simultaneous mode (`mode_req`=1), `adc_ss` is 1. A channel-2 word carries the same `out_index` as the channel-1 word just before it, and the index goes up by one per pair.
- R7: `out_data` is the converter word received nine cycles after the edge at which its tag was sampled. With `twos_comp`=0 it is unchanged. With `twos_comp`=1, bit 13 (the MSB) is inverted and bits 12..0 are unchanged.
- R8: `mode_req` is taken into `adc_ss` only on edges where `enable` is low. A change of `mode_req` while running has no effect on `adc_ss` or on the indexing pattern.
- R9: After a power-down in mid-run, no word that was in flight is reported as valid. A new start-up repeats the full wait and restarts the index at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion / system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low puts the converter into power-down |
| mode_req | input | 1 | Requested mode: 0 separate, 1 simultaneous |
| twos_comp | input | 1 | 1 converts output words to two's complement |
| adc_data | input | DATA_W | Parallel straight-binary word from the converter |
| adc_pdn_n | output | 1 | Converter power-down, active low |
| adc_ss | output | 1 | Converter sampling mode (1 = simultaneous) |
| adc_sel | output | 1 | Converter channel select (0 = channel 1) |
| out_valid | output | 1 | Output word is a real, tagged sample |
| out_chan | output | 1 | Channel of the output word |
| out_index | output | IDX_W | Sample or pair index of the output word |
| out_data | output | DATA_W | Output word, formatted |

## Verification
The assertions assume three things about the inputs:
- `enable` is a synchronous level that stays high for a whole run.
- `mode_req` may move at any time, including while running, which is exactly the case the mode-hold property covers.
- The converter behind `adc_data` really has eight cycles of latency.

The bench keeps within these assumptions in the following ways:
- It drives every input just after the falling edge.
- It models the converter as an eight-register delay line. That model holds the channel-2 value captured at the select-low edge when in simultaneous mode.
- It changes `enable` only at clean run boundaries.
- It produces ramp data whose value depends on channel and sampling time, so a tag that is one cycle early or late gives a different word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    SMODE_SEPARATE = 1'b0,
    SMODE_PAIRED   = 1'b1
  } smode_e;

  // Index advance after a sampling edge: a paired capture keeps the
  // same index for its channel-2 word.
  function automatic logic idx_bump(input smode_e mode, input logic sel_now);
    return (mode == SMODE_SEPARATE) || sel_now;
  endfunction

  // MSB transform for the two's complement view of a straight-binary word.
  function automatic logic msb_fmt(input logic msb, input logic twos);
    return msb ^ twos;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned STARTUP_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_req,
  output logic             pdn_n,
  output logic             ss,
  output logic             sel,
  output logic             armed,
  output logic             flush,
  output logic             mode_ignored,
  output logic             tag_vld,
  output logic             tag_chan,
  output logic [IDX_W-1:0] tag_idx
);
  localparam int unsigned CNT_W   = (STARTUP_CYC < 2) ? 1 : $clog2(STARTUP_CYC);
  localparam int unsigned CNT_END = (STARTUP_CYC < 1) ? 0 : STARTUP_CYC - 1;

  logic             pdn_q;
  smode_e           mode_q;
  logic [CNT_W-1:0] wait_cnt;
  logic             armed_q;
  logic             sel_q;
  logic [IDX_W-1:0] idx_q;
  logic             wait_done;

  assign wait_done    = (wait_cnt == CNT_W'(CNT_END));
  assign flush        = !enable || !pdn_q;
  assign mode_ignored = pdn_q && enable && (smode_e'(mode_req) != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q    <= 1'b0;
      mode_q   <= SMODE_SEPARATE;
      wait_cnt <= '0;
      armed_q  <= 1'b0;
      sel_q    <= 1'b0;
      idx_q    <= '0;
    end else begin
      pdn_q <= enable;
      if (!enable) mode_q <= smode_e'(mode_req);
      if (flush) begin
        wait_cnt <= '0;
        armed_q  <= 1'b0;
        sel_q    <= 1'b0;
        idx_q    <= '0;
      end else if (!armed_q) begin
        if (wait_done) armed_q  <= 1'b1;
        else           wait_cnt <= wait_cnt + 1'b1;
      end else begin
        sel_q <= ~sel_q;
        idx_q <= idx_q + IDX_W'(idx_bump(mode_q, sel_q));
      end
    end
  end

  assign pdn_n    = pdn_q;
  assign ss       = mode_q;
  assign sel      = sel_q;
  assign armed    = armed_q;
  assign tag_vld  = armed_q;
  assign tag_chan = sel_q;
  assign tag_idx  = idx_q;

endmodule

// File: rtl/adc_seq_tagpipe.sv
module adc_seq_tagpipe #(
  parameter int unsigned DEPTH = 9,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_vld,
  input  logic             in_chan,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_vld,
  output logic             out_chan,
  output logic [IDX_W-1:0] out_idx
);
  logic             st_vld  [DEPTH];
  logic             st_chan [DEPTH];
  logic [IDX_W-1:0] st_idx  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic             nxt_vld;
    logic             nxt_chan;
    logic [IDX_W-1:0] nxt_idx;

    if (g == 0) begin : g_head
      assign nxt_vld  = in_vld;
      assign nxt_chan = in_chan;
      assign nxt_idx  = in_idx;
    end else begin : g_body
      assign nxt_vld  = st_vld[g-1];
      assign nxt_chan = st_chan[g-1];
      assign nxt_idx  = st_idx[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_vld[g]  <= 1'b0;
        st_chan[g] <= 1'b0;
        st_idx[g]  <= '0;
      end else begin
        st_vld[g]  <= nxt_vld && !flush;
        st_chan[g] <= nxt_chan;
        st_idx[g]  <= nxt_idx;
      end
    end
  end

  assign out_vld  = st_vld[DEPTH-1];
  assign out_chan = st_chan[DEPTH-1];
  assign out_idx  = st_idx[DEPTH-1];

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              twos_comp,
  input  logic              tag_vld,
  input  logic              tag_chan,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [DATA_W-1:0] raw,
  output logic              out_valid,
  output logic              out_chan,
  output logic [IDX_W-1:0]  out_index,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] shaped;

  assign shaped = {msb_fmt(raw[DATA_W-1], twos_comp), raw[DATA_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_index <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= tag_vld && !flush;
      out_chan  <= tag_chan;
      out_index <= tag_idx;
      out_data  <= shaped;
    end
  end

endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq #(
  parameter int unsigned DATA_W      = 14,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned ADC_LAT     = 8,
  parameter int unsigned STARTUP_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_req,
  input  logic              twos_comp,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_pdn_n,
  output logic              adc_ss,
  output logic              adc_sel,
  output logic              out_valid,
  output logic              out_chan,
  output logic [IDX_W-1:0]  out_index,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned TAG_DEPTH = ADC_LAT + 1;

  logic             armed;
  logic             flush;
  logic             mode_ignored;
  logic             issue_vld;
  logic             issue_chan;
  logic [IDX_W-1:0] issue_idx;
  logic             align_vld;
  logic             align_chan;
  logic [IDX_W-1:0] align_idx;

  adc_seq_ctrl #(
    .IDX_W      (IDX_W),
    .STARTUP_CYC(STARTUP_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mode_req    (mode_req),
    .pdn_n       (adc_pdn_n),
    .ss          (adc_ss),
    .sel         (adc_sel),
    .armed       (armed),
    .flush       (flush),
    .mode_ignored(mode_ignored),
    .tag_vld     (issue_vld),
    .tag_chan    (issue_chan),
    .tag_idx     (issue_idx)
  );

  adc_seq_tagpipe #(
    .DEPTH(TAG_DEPTH),
    .IDX_W(IDX_W)
  ) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .in_vld  (issue_vld),
    .in_chan (issue_chan),
    .in_idx  (issue_idx),
    .out_vld (align_vld),
    .out_chan(align_chan),
    .out_idx (align_idx)
  );

  adc_seq_fmt #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .twos_comp(twos_comp),
    .tag_vld  (align_vld),
    .tag_chan (align_chan),
    .tag_idx  (align_idx),
    .raw      (adc_data),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_index(out_index),
    .out_data (out_data)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned STARTUP_CYC = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_pdn_n,
  input logic             adc_ss,
  input logic             adc_sel,
  input logic             armed,
  input logic             mode_ignored,
  input logic             out_valid,
  input logic             out_chan,
  input logic [IDX_W-1:0] out_index
);
  int unsigned up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          up_cnt <= 0;
    else if (!adc_pdn_n) up_cnt <= 0;
    else                 up_cnt <= up_cnt + 1;
  end

  AST_PDN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_pdn_n |-> !out_valid); // R1
  AST_SEL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> (adc_sel != $past(adc_sel))); // R2
  AST_SEL_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !adc_sel); // R2
  AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> (up_cnt == STARTUP_CYC)); // R3
  AST_CHAN_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_chan != $past(out_chan))); // R4
  AST_PAIR_SHARES_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && adc_ss && out_chan) |-> (out_index == $past(out_index))); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ignored |=> $stable(adc_ss)); // R8

endmodule

bind adc_capture_seq adc_seq_chk #(
  .IDX_W      (IDX_W),
  .STARTUP_CYC(STARTUP_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_pdn_n   (adc_pdn_n),
  .adc_ss      (adc_ss),
  .adc_sel     (adc_sel),
  .armed       (armed),
  .mode_ignored(mode_ignored),
  .out_valid   (out_valid),
  .out_chan    (out_chan),
  .out_index   (out_index)
);

// File: tb/adc_capture_seq_bench.sv
module adc_capture_seq_bench;
  localparam int unsigned DW = 14;
  localparam int unsigned IW = 8;
  localparam int unsigned S  = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          mode_req = 1'b0;
  logic          twos_comp = 1'b0;
  logic [DW-1:0] adc_data;
  logic          adc_pdn_n, adc_ss, adc_sel;
  logic          out_valid, out_chan;
  logic [IW-1:0] out_index;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_capture_seq #(.DATA_W(DW), .IDX_W(IW), .ADC_LAT(8), .STARTUP_CYC(S)) u_adc_capture_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_req(mode_req),
    .twos_comp(twos_comp), .adc_data(adc_data), .adc_pdn_n(adc_pdn_n),
    .adc_ss(adc_ss), .adc_sel(adc_sel), .out_valid(out_valid),
    .out_chan(out_chan), .out_index(out_index), .out_data(out_data));

  // Converter model: two sample-and-holds, eight cycles of latency.
  function automatic logic [DW-1:0] ramp(input logic ch, input int t);
    return ch ? DW'(14'h3000 - 7 * t) : DW'(14'h0100 + 13 * t);
  endfunction

  int            mcnt;
  logic [DW-1:0] hold2;
  logic [DW-1:0] mpipe [8];
  logic [DW-1:0] conv_val;

  assign conv_val = !adc_ss ? ramp(adc_sel, mcnt) : (!adc_sel ? ramp(1'b0, mcnt) : hold2);

  always @(posedge clk) begin
    if (!adc_pdn_n) begin
      mcnt  <= 0;
      hold2 <= '0;
      for (int i = 0; i < 8; i++) mpipe[i] <= '0;
      adc_data <= '0;
    end else begin
      mcnt <= mcnt + 1;
      if (adc_ss && !adc_sel) hold2 <= ramp(1'b1, mcnt);
      mpipe[0] <= conv_val;
      for (int i = 1; i < 8; i++) mpipe[i] <= mpipe[i-1];
      adc_data <= mpipe[7];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_word(input int k, input logic mode, input logic twos);
    logic          ch;
    int            t;
    logic [DW-1:0] d;
    ch = k[0];
    t  = S + k - ((mode && ch) ? 1 : 0);
    d  = ramp(ch, t);
    if (twos) d[DW-1] = ~d[DW-1];
    chk("R4 valid run", {31'd0, out_valid}, 32'd1);
    chk("R4 chan", {31'd0, out_chan}, {31'd0, ch});
    if (mode) chk("R6 pair index", {24'd0, out_index}, 32'(IW'(k / 2)));
    else      chk("R5 index", {24'd0, out_index}, 32'(IW'(k)));
    chk(twos ? "R7 twos data" : "R7 data", {18'd0, out_data}, {18'd0, d});
  endtask

  // Power up in a given mode, check the first-word latency, check word 0.
  task automatic run_up(input logic mode, input logic twos);
    int edges = 0;
    @(negedge clk);
    enable = 1'b0; mode_req = mode; twos_comp = twos;
    repeat (3) @(negedge clk);
    chk("R1 pdn low", {31'd0, adc_pdn_n}, 32'd0);
    chk("R8 mode taken in pdn", {31'd0, adc_ss}, {31'd0, mode});
    enable = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (i == S / 2) chk("R2 sel idle in wait", {31'd0, adc_sel}, 32'd0);
      if (out_valid) break;
    end
    chk("R3 latency", 32'(edges), 32'(S + 11));
    check_word(0, mode, twos);
  endtask

  task automatic collect(input int k0, input int n, input logic mode, input logic twos);
    for (int k = k0; k < k0 + n; k++) begin
      @(negedge clk);
      check_word(k, mode, twos);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pdn", {31'd0, adc_pdn_n}, 32'd0);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R2 reset sel", {31'd0, adc_sel}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_separate();
    run_up(1'b0, 1'b0);
    collect(1, 30, 1'b0, 1'b0);
  endtask

  task automatic t_paired();
    run_up(1'b1, 1'b0);
    chk("R6 ss high", {31'd0, adc_ss}, 32'd1);
    collect(1, 30, 1'b1, 1'b0);
  endtask

  task automatic t_twos();
    run_up(1'b0, 1'b1);
    collect(1, 12, 1'b0, 1'b1);
  endtask

  task automatic t_mode_reject();
    run_up(1'b1, 1'b0);
    collect(1, 5, 1'b1, 1'b0);
    mode_req = 1'b0;
    collect(6, 16, 1'b1, 1'b0);
    chk("R8 ss kept", {31'd0, adc_ss}, 32'd1);
  endtask

  task automatic t_pdn_midrun();
    int seen = 0;
    run_up(1'b0, 1'b0);
    collect(1, 7, 1'b0, 1'b0);
    enable = 1'b0;
    @(negedge clk);
    chk("R1 pdn after drop", {31'd0, adc_pdn_n}, 32'd0);
    chk("R1 valid after drop", {31'd0, out_valid}, 32'd0);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk("R9 no stale words", 32'(seen), 32'd0);
    run_up(1'b0, 1'b0);
    collect(1, 6, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_separate();
    t_paired();
    t_twos();
    t_mode_reject();
    t_pdn_midrun();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule